// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns a single transfer request into one complete external bus cycle on a bus whose lines carry the address first and data afterwards. Each cycle passes through the T-states T1, T2, T3, zero or more wait states (TW) and T4. In T1 the address is placed on the shared lines and a latch-enable pulse is issued so that an external latch can hold it. The lines then carry write data, or are released for the addressed device to return read data. A three-bit status code announces the kind of cycle while it is valid and returns to the passive code otherwise.

A slow device stretches a cycle by holding `ready` low. Another bus master can take the bus with `hold`. The sequencer finishes any cycle already in progress, raises `hlda` and releases every bus and control output. It takes the bus back once `hold` drops. Requests are taken whenever the sequencer is idle or in T4, so cycles can run back to back with no dead clock between them. The tri-state pins are modelled as values paired with output-enable flags.

Top module: `mux_bus_seq`

## Requirements
- R1: With `ready` high, a cycle takes exactly four clocks (T1, T2, T3, T4). Every wait state adds exactly one clock between T3 and T4.
- R2: In T1 `ale` is high, `ad_oe` is high and `ad_out` equals the request address. `ale` is low in every other state, and it is never released.
- R3: Status codes are 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write and 111 passive. `stat` shows the cycle's code in T1 and T2 and 111 in T3 and TW. In T4 it shows the next cycle's code when a request is taken in that clock, and 111 otherwise.
- R4: Write kinds (010, 110) drive `ad_out` = request data zero-extended, with `ad_oe` high, from T2 through T4. `wr_n` is low from T2 through T4.
- R5: Read kinds (000, 001, 100, 101) release the bus (`ad_oe` low) from T2 through T4. `rd_n` is low in T2, T3 and TW and high in T4. `rd_n` and `wr_n` are never low together.
- R6: The halt kind (011) drives the address in T1 only, and it asserts neither strobe.
- R7: `ready` is sampled at the clock edge that ends T3 and at the edge that ends each TW. A low sample inserts a TW, in which `stat` is 111 and `done` is low.
- R8: For read kinds, `rdata` takes the value of `ad_in` at the edge that leaves the last T3 or TW. `done` is high during T4 for every kind.
- R9: `hold` is acted on only in the idle state or in T4. `hlda` rises one clock later. While `hlda` is high, `ad_oe`, `ctl_oe` and `ale` are low and no request is taken. If `hold` rises during a cycle, the cycle completes first.
- R10: One clock after `hold` falls, `hlda` is low, `ctl_oe` is high and a pending request is taken.
- R11: With no request, the sequencer idles with `stat` = 111, both strobes high, `ale` low and `ad_oe` low. This is also the reset state.
- R12: `req_ready` is high in the idle state and in T4 while `hold` is low. A request taken in T4 starts its T1 on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_kind | input | 3 | Cycle kind, same code as `stat` |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request taken this clock when `req_valid` is high |
| done | output | 1 | High during T4 |
| rdata | output | DW | Captured read data |
| ad_out | output | AW | Shared bus drive value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | DW | Shared bus read value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| stat | output | 3 | Cycle status code |
| ctl_oe | output | 1 | Enable for strobes and status |
| ready | input | 1 | Device ready, low inserts waits |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |

## Verification
A corrupted T-state register shows up at the pins within one clock. `ale` pulses at the wrong time, a strobe opens or closes early, or `stat` fails to go passive two clocks after `ale`. A wrong wait-state decision moves `done` and the read capture by a whole clock, so the T4 checks and the `rdata` comparison catch it on that cycle. A mishandled hold shows either as `hlda` rising inside a cycle or as the bus still driven while `hlda` is high, and the hold checks sample both on the clock it occurs.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [2:0]    stat,
  output logic          ctl_oe,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda
);
  localparam logic [2:0] PASSIVE = 3'b111;
  localparam int PADW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_HOLD} tstate_t;

  tstate_t st, st_nx;
  logic [2:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  wire accept  = req_valid && req_ready;
  wire in_wait = (st == S_T3) || (st == S_TW);
  wire leave   = in_wait && ready;
  wire mid     = (st == S_T2) || in_wait;
  wire is_rd   = kind_q inside {3'b000, 3'b001, 3'b100, 3'b101};
  wire is_wr   = (kind_q == 3'b010) || (kind_q == 3'b110);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE, S_T4: st_nx = hold ? S_HOLD : (req_valid ? S_T1 : S_IDLE);
      S_T1:         st_nx = S_T2;
      S_T2:         st_nx = S_T3;
      S_T3, S_TW:   st_nx = ready ? S_T4 : S_TW;
      S_HOLD:       st_nx = hold ? S_HOLD : S_IDLE;
      default:      st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_q  <= PASSIVE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        kind_q  <= req_kind;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (leave && is_rd) rdata <= ad_in;
    end
  end

  assign req_ready = ((st == S_IDLE) || (st == S_T4)) && !hold;
  assign done      = (st == S_T4);
  assign ale       = (st == S_T1);
  assign ad_oe     = (st == S_T1) || (is_wr && (mid || st == S_T4));
  assign ad_out    = (st == S_T1) ? addr_q : {{PADW{1'b0}}, wdata_q};
  assign rd_n      = !(is_rd && mid);
  assign wr_n      = !(is_wr && (mid || st == S_T4));
  assign stat      = (st == S_T1 || st == S_T2) ? kind_q :
                     (st == S_T4 && accept)     ? req_kind : PASSIVE;
  assign hlda      = (st == S_HOLD);
  assign ctl_oe    = (st != S_HOLD);

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_passive_after_t2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ale, 2) |-> (stat == PASSIVE));
  assert_wdata_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(ad_out));
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  assert_wait_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !ready) |=> (stat == PASSIVE && !done));
  assert_done_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(ready));
  assert_hold_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ad_oe && !ctl_oe && !ale && !req_ready));
  assert_hold_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && st == S_T2) |=> !hlda);
endmodule

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, ready = 1, hold = 0;
  logic [2:0] req_kind = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0, ad_in = 0;
  logic req_ready, done, ad_oe, ale, rd_n, wr_n, ctl_oe, hlda;
  logic [DW-1:0] rdata;
  logic [AW-1:0] ad_out;
  logic [2:0] stat;
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_seq #(.AW(AW), .DW(DW)) u_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .stat(stat), .ctl_oe(ctl_oe),
    .ready(ready), .hold(hold), .hlda(hlda));

  function automatic bit reads(input logic [2:0] k);
    return (k == 3'd0) || (k == 3'd1) || (k == 3'd4) || (k == 3'd5);
  endfunction
  function automatic bit writes(input logic [2:0] k);
    return (k == 3'd2) || (k == 3'd6);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " stat"}, stat, 3'b111);
    chk({tag, " strobes/ale/oe"}, {rd_n, wr_n, ale, ad_oe}, 4'b1100);
  endtask

  task automatic run(input logic [2:0] k, input logic [AW-1:0] a, input logic [DW-1:0] w,
                     input int nw, input logic [DW-1:0] rv, input bit pre, input bit hold_mid,
                     input bit chain, input logic [2:0] ck, input logic [AW-1:0] ca,
                     input logic [DW-1:0] cw);
    bit rk, wk;
    rk = reads(k);
    wk = writes(k);
    if (!pre) begin
      @(negedge clk);
      req_valid = 1; req_kind = k; req_addr = a; req_wdata = w; #1;
      chk("R12 ready in idle", req_ready, 1);
      check_idle("R11 idle");
    end
    @(negedge clk); req_valid = 0; #1;
    chk("R2 ale in T1", ale, 1);
    chk("R2 address", {ad_oe, ad_out}, {1'b1, a});
    chk("R3 stat T1", stat, k);
    chk("R1 no done in T1", done, 0);
    @(negedge clk); if (hold_mid) hold = 1; #1;
    chk("R3 stat T2", stat, k);
    chk("R2 ale low T2", ale, 0);
    chk("R5 rd_n T2", rd_n, !rk);
    chk("R4 wr_n T2", wr_n, !wk);
    chk("R4 R5 R6 bus oe T2", ad_oe, wk);
    if (wk) chk("R4 write data", ad_out, {{(AW-DW){1'b0}}, w});
    if (hold_mid) chk("R9 hold deferred T2", hlda, 0);
    @(negedge clk); ad_in = rv; ready = (nw == 0); #1;
    chk("R3 stat T3 passive", stat, 3'b111);
    chk("R1 no done in T3", done, 0);
    for (int i = 0; i < nw; i++) begin
      @(negedge clk); ready = (i == nw - 1); #1;
      chk("R7 wait stat", stat, 3'b111);
      chk("R7 wait no done", done, 0);
      chk("R5 rd_n in wait", rd_n, !rk);
      chk("R4 wr_n in wait", wr_n, !wk);
    end
    @(negedge clk);
    ready = 1; ad_in = DW'($urandom);
    if (chain) begin
      req_valid = 1; req_kind = ck; req_addr = ca; req_wdata = cw;
    end
    #1;
    chk("R8 done in T4", done, 1);
    if (rk) chk("R8 read data", rdata, rv);
    chk("R5 rd_n high T4", rd_n, 1);
    chk("R4 wr_n T4", wr_n, !wk);
    chk("R3 stat T4", stat, (chain && !hold) ? ck : 3'b111);
    if (hold_mid) chk("R9 no grant in T4", {hlda, req_ready}, 2'b00);
    if (chain) chk("R12 ready in T4", req_ready, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit pre;
    logic [2:0] nk;
    logic [AW-1:0] na;
    logic [DW-1:0] nwd;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    #1;
    check_idle("R11 reset");
    chk("R9 reset hlda", hlda, 0);
    rst_n = 1;

    run(3'd5, 20'hABCDE, 16'h0, 0, 16'h1234, 0, 0, 0, 0, 0, 0);
    run(3'd6, 20'h12345, 16'hBEEF, 2, 16'h0, 0, 0, 0, 0, 0, 0);
    run(3'd3, 20'hFFFF0, 16'h0, 0, 16'h0, 0, 0, 0, 0, 0, 0);
    #1 chk("R6 halt no strobes", {rd_n, wr_n, ad_oe}, 3'b110);
    run(3'd1, 20'h00040, 16'h0, 3, 16'h5A5A, 0, 0, 1, 3'd2, 20'h00041, 16'h00C3);
    run(3'd2, 20'h00041, 16'h00C3, 0, 16'h0, 1, 0, 0, 0, 0, 0);

    run(3'd4, 20'h0F00F, 16'h0, 1, 16'h7777, 0, 1, 0, 0, 0, 0);
    @(negedge clk); #1;
    chk("R9 hlda after cycle", hlda, 1);
    chk("R9 bus released", {ad_oe, ctl_oe, ale}, 3'b000);
    hold = 0;
    @(negedge clk); #1;
    chk("R10 hlda dropped", {hlda, ctl_oe}, 2'b01);

    @(negedge clk);
    hold = 1; req_valid = 1; req_kind = 3'd5; req_addr = 20'h33333; #1;
    chk("R9 hold beats request", req_ready, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R9 held, no cycle", {hlda, ale, ad_oe, ctl_oe}, 4'b1000);
    end
    hold = 0;
    @(negedge clk); #1;
    chk("R10 released", {hlda, req_ready}, 2'b01);
    @(negedge clk); req_valid = 0; #1;
    chk("R10 cycle resumes", {ale, ad_out}, {1'b1, 20'h33333});
    ready = 1;
    repeat (3) @(negedge clk);

    pre = 0;
    nk = 3'($urandom_range(0, 6));
    na = AW'($urandom); nwd = DW'($urandom);
    for (int t = 0; t < 60; t++) begin
      logic [2:0] k;
      logic [AW-1:0] a;
      logic [DW-1:0] w;
      bit ch;
      k = nk; a = na; w = nwd;
      nk = 3'($urandom_range(0, 6));
      na = AW'($urandom); nwd = DW'($urandom);
      ch = ($urandom_range(0, 2) == 0);
      run(k, a, w, $urandom_range(0, 3), DW'($urandom), pre, 0, ch, nk, na, nwd);
      pre = ch;
    end
    if (pre) begin
      @(negedge clk); req_valid = 0;
      repeat (4) @(negedge clk);
    end
    @(negedge clk); #1;
    check_idle("R11 final idle");
    finish_run();
  end
endmodule